// File: doc/BRIEF.md
# Dual-Line ADC Serial Readout Controller

This block is the master side of a serial link to an eight-channel, 18-bit converter. After a start strobe it pulls chip select low, waits a programmable setup time, and runs a divided serial clock. It captures the returned results either from two data lines at once or from a single line. Each result is a two's complement value, shifted MSB first over 18 clock periods. The first MSB is already on the line when chip select falls, so it is taken just before the first rising edge. Every later bit is taken while the clock is high, just before the falling edge, because the converter changes its output on the rising edge.

In dual-line mode line A returns channels 1 to 4 and line B returns channels 5 to 8 in parallel, which takes 72 clock periods. In single-line mode one line is read for 144 periods. Line A gives channels 1 to 8. Line B gives 5, 6, 7, 8 and then 1, 2, 3, 4. Whatever the mode, the captured words leave on a valid/ready stream in channel order, sign-extended and tagged with a channel index. The word on offer holds until ready is seen high, and the next word follows in the next cycle. A new start is accepted only when the last word of the previous frame has been taken.

Top module: `adc_dual_readout`

## Requirements
- R1: After an accepted start, `cs_n_o` goes low once and stays low for exactly 72 rising edges of `sclk_o` when `dual_i` was 1, or 144 rising edges when it was 0, and then returns high.
- R2: `sclk_o` is low whenever `cs_n_o` is high. While shifting, each clock level lasts `half_div_i` system cycles, with 0 treated as 1.
- R3: The first rising edge of `sclk_o` comes exactly `setup_i` system cycles after `cs_n_o` falls, with 0 treated as 1.
- R4: Bit 17 (the MSB) of the first word is sampled in the cycle before the first rising edge. Each later bit is sampled in the last high cycle before a falling edge. The 18 bits of a channel arrive MSB first.
- R5: With `dual_i`=1, line A (`sdo_a_i`) supplies channels 1-4 and line B (`sdo_b_i`) supplies channels 5-8 at the same time.
- R6: With `dual_i`=0, the line is line A when `single_b_i`=0, read as channels 1-8. It is line B when `single_b_i`=1, read as channels 5,6,7,8,1,2,3,4.
- R7: Eight words leave in channel order. `word_chan_o` is 0 for channel 1 up to 7 for channel 8. `word_data_o` is the 18-bit result sign-extended from bit 17.
- R8: While `word_valid_o`=1 and `word_ready_i`=0, the valid, data and channel outputs hold their values into the next cycle.
- R9: `frame_done_o` is a one-cycle pulse in the first cycle that `cs_n_o` is high again. No word is valid before that cycle.
- R10: A start is ignored from the moment one is accepted until the eighth word has been taken.
- R11: After reset `cs_n_o`=1, `sclk_o`=0, `word_valid_o`=0 and `frame_done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; begins a frame when idle |
| dual_i | input | 1 | 1: two-line capture, 0: single-line capture |
| single_b_i | input | 1 | In single-line mode, 1 reads line B instead of line A |
| half_div_i | input | DIV_W | System cycles per serial clock level |
| setup_i | input | SET_W | System cycles from chip select low to first rising edge |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_a_i | input | 1 | Converter data line A |
| sdo_b_i | input | 1 | Converter data line B |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Consumer ready |
| word_data_o | output | OUT_W | Sign-extended channel result |
| word_chan_o | output | $clog2(N_CH) | Channel index, 0 for channel 1 |
| frame_done_o | output | 1 | One-cycle pulse when chip select rises |

## Verification
Some rules are local in time, and assertions check them on every cycle. The serial clock stays low while chip select is high. A clock level never changes before its half-period ends. A stalled word holds still. The done pulse lasts one cycle. Chip select never falls while a frame is still open. The two capture lanes never write the same channel slot, and in dual mode no lane collects more than four words.

Other behaviour spans a whole frame, and only the bench scenarios can show it. These are the exact count of rising edges, the setup gap, and the correct placement of every bit, including the MSB that precedes the first edge. The bench scenarios also cover the reordering of line B in single-line mode and the sign extension of full-scale negative and positive codes.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_CLOSE,
    ST_DRAIN
  } rd_state_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] ph_q;
  logic             sclk_q;
  logic             term;

  assign term   = (ph_q == half_m1_i);
  assign rise_o = kick_i | (run_i & ~sclk_q & term);
  assign fall_o = run_i & sclk_q & term;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (kick_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else if (run_i) begin
      if (term) begin
        ph_q   <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end else begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end
  end

  // R2: a clock level is held until its half period has elapsed
  a_r2_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !term && !kick_i) |=> $stable(sclk_o));
endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
  parameter int CH_BITS  = 18,
  parameter int N_CH     = 8,
  parameter int SLOT_OFS = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    en_i,
  input  logic                    dual_i,
  input  logic                    smp_i,
  input  logic                    din_i,
  output logic                    wr_en_o,
  output logic [$clog2(N_CH)-1:0] wr_slot_o,
  output logic [CH_BITS-1:0]      wr_word_o
);
  localparam int SLOT_W = $clog2(N_CH);
  localparam int BIT_W  = $clog2(CH_BITS);
  localparam int WCNT_W = $clog2(N_CH + 1);

  logic [CH_BITS-1:0] sh_q;
  logic [BIT_W-1:0]   bit_q;
  logic [WCNT_W-1:0]  word_q;
  logic [CH_BITS-1:0] next_sh;

  assign next_sh = {sh_q[CH_BITS-2:0], din_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      bit_q     <= '0;
      word_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_slot_o <= '0;
      wr_word_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (clear_i) begin
        bit_q  <= '0;
        word_q <= '0;
      end else if (smp_i && en_i) begin
        sh_q <= next_sh;
        if (bit_q == BIT_W'(CH_BITS - 1)) begin
          bit_q     <= '0;
          word_q    <= word_q + 1'b1;
          wr_en_o   <= 1'b1;
          wr_word_o <= next_sh;
          wr_slot_o <= SLOT_W'(int'(word_q) + SLOT_OFS);
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // R5: in two-line mode a lane delivers at most half of the channels
  a_r5_dual_half_words: assert property (@(posedge clk) disable iff (!rst_n)
    dual_i |-> (word_q <= WCNT_W'(N_CH / 2)));
endmodule

// File: rtl/adc_rd_store.sv
module adc_rd_store #(
  parameter int CH_BITS = 18,
  parameter int N_CH    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_a_i,
  input  logic [$clog2(N_CH)-1:0] slot_a_i,
  input  logic [CH_BITS-1:0]      word_a_i,
  input  logic                    we_b_i,
  input  logic [$clog2(N_CH)-1:0] slot_b_i,
  input  logic [CH_BITS-1:0]      word_b_i,
  input  logic [$clog2(N_CH)-1:0] rd_slot_i,
  output logic [CH_BITS-1:0]      rd_word_o
);
  logic [CH_BITS-1:0] mem_q [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) mem_q[i] <= '0;
    end else begin
      if (we_a_i) mem_q[slot_a_i] <= word_a_i;
      if (we_b_i) mem_q[slot_b_i] <= word_b_i;
    end
  end

  assign rd_word_o = mem_q[rd_slot_i];

  // R5: parallel lanes never land on the same channel slot
  a_r5_slot_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a_i && we_b_i) |-> (slot_a_i != slot_b_i));
endmodule

// File: rtl/adc_dual_readout.sv
module adc_dual_readout
  import adc_rd_pkg::*;
#(
  parameter int CH_BITS = 18,
  parameter int N_CH    = 8,
  parameter int OUT_W   = 24,
  parameter int DIV_W   = 8,
  parameter int SET_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    dual_i,
  input  logic                    single_b_i,
  input  logic [DIV_W-1:0]        half_div_i,
  input  logic [SET_W-1:0]        setup_i,
  output logic                    cs_n_o,
  output logic                    sclk_o,
  input  logic                    sdo_a_i,
  input  logic                    sdo_b_i,
  output logic                    word_valid_o,
  input  logic                    word_ready_i,
  output logic [OUT_W-1:0]        word_data_o,
  output logic [$clog2(N_CH)-1:0] word_chan_o,
  output logic                    frame_done_o
);
  localparam int SLOT_W     = $clog2(N_CH);
  localparam int LEN_DUAL   = (N_CH / 2) * CH_BITS;
  localparam int LEN_SINGLE = N_CH * CH_BITS;
  localparam int CNT_W      = $clog2(LEN_SINGLE + 1);
  localparam int N_LANE     = 2;

  rd_state_t         state_q;
  logic              dual_q, selb_q, cs_n_q, done_q;
  logic [DIV_W-1:0]  half_m1_q;
  logic [SET_W-1:0]  setup_m1_q, set_cnt_q;
  logic [CNT_W-1:0]  rise_cnt_q, frame_len;
  logic [SLOT_W-1:0] rd_ptr_q;

  logic kick, run, rise_now, fall_now, last_fall, smp, accept, take;
  logic [N_LANE-1:0] lane_en, lane_din, lane_we;
  logic [SLOT_W-1:0]  lane_slot [N_LANE];
  logic [CH_BITS-1:0] lane_word [N_LANE];
  logic [CH_BITS-1:0] rd_word;

  assign frame_len = dual_q ? CNT_W'(LEN_DUAL) : CNT_W'(LEN_SINGLE);
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign kick      = (state_q == ST_SETUP) && (set_cnt_q == setup_m1_q);
  assign run       = (state_q == ST_SHIFT);
  assign last_fall = fall_now && (rise_cnt_q == frame_len);
  assign smp       = kick || (fall_now && !last_fall);
  assign take      = word_valid_o && word_ready_i;

  adc_rd_sclk_gen #(.DIV_W(DIV_W)) sclk_i (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .run_i(run),
    .half_m1_i(half_m1_q), .sclk_o(sclk_o), .rise_o(rise_now), .fall_o(fall_now)
  );

  assign lane_en  = {dual_q | selb_q, dual_q | ~selb_q};
  assign lane_din = {sdo_b_i, sdo_a_i};

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    adc_rd_lane #(.CH_BITS(CH_BITS), .N_CH(N_CH), .SLOT_OFS(g * (N_CH / 2))) lane_i (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .en_i(lane_en[g]),
      .dual_i(dual_q), .smp_i(smp), .din_i(lane_din[g]),
      .wr_en_o(lane_we[g]), .wr_slot_o(lane_slot[g]), .wr_word_o(lane_word[g])
    );
  end

  adc_rd_store #(.CH_BITS(CH_BITS), .N_CH(N_CH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we_a_i(lane_we[0]), .slot_a_i(lane_slot[0]), .word_a_i(lane_word[0]),
    .we_b_i(lane_we[1]), .slot_b_i(lane_slot[1]), .word_b_i(lane_word[1]),
    .rd_slot_i(rd_ptr_q), .rd_word_o(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dual_q     <= 1'b0;
      selb_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      half_m1_q  <= '0;
      setup_m1_q <= '0;
      set_cnt_q  <= '0;
      rise_cnt_q <= '0;
      rd_ptr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          dual_q     <= dual_i;
          selb_q     <= single_b_i;
          half_m1_q  <= (half_div_i == '0) ? '0 : half_div_i - 1'b1;
          setup_m1_q <= (setup_i == '0) ? '0 : setup_i - 1'b1;
          set_cnt_q  <= '0;
          rise_cnt_q <= '0;
          cs_n_q     <= 1'b0;
          state_q    <= ST_SETUP;
        end
        ST_SETUP: if (kick) begin
          rise_cnt_q <= CNT_W'(1);
          state_q    <= ST_SHIFT;
        end else begin
          set_cnt_q <= set_cnt_q + 1'b1;
        end
        ST_SHIFT: begin
          if (rise_now) rise_cnt_q <= rise_cnt_q + 1'b1;
          if (last_fall) state_q <= ST_CLOSE;
        end
        ST_CLOSE: begin
          cs_n_q   <= 1'b1;
          done_q   <= 1'b1;
          rd_ptr_q <= '0;
          state_q  <= ST_DRAIN;
        end
        ST_DRAIN: if (take) begin
          if (rd_ptr_q == SLOT_W'(N_CH - 1)) state_q <= ST_IDLE;
          else rd_ptr_q <= rd_ptr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o       = cs_n_q;
  assign frame_done_o = done_q;
  assign word_valid_o = (state_q == ST_DRAIN);
  assign word_chan_o  = rd_ptr_q;
  assign word_data_o  = {{(OUT_W - CH_BITS){rd_word[CH_BITS-1]}}, rd_word};

  // R2: the serial clock idles low outside a frame
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  // R1: rising edges never exceed the frame length
  a_r1_edge_budget: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt_q <= frame_len);
  // R8: a stalled word holds still
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_chan_o)));
  // R9: the done strobe is a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  // R10: no new frame opens while one is still in progress
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> !$fell(cs_n_o));
endmodule

// File: tb/adc_dual_readout_tb_top.sv
module adc_dual_readout_tb_top;
  typedef struct packed {
    logic       dual;
    logic       selb;
    logic [7:0] half;
    logic [3:0] setup;
    logic [7:0] seed;
    logic [3:0] rdy;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd1, 4'd1, 8'd0,  4'hF},
    '{1'b1, 1'b1, 8'd2, 4'd3, 8'd5,  4'h5},
    '{1'b0, 1'b0, 8'd1, 4'd2, 8'd9,  4'hF},
    '{1'b0, 1'b1, 8'd3, 4'd0, 8'd17, 4'h3},
    '{1'b0, 1'b1, 8'd2, 4'd4, 8'd0,  4'hF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dual = 1'b0, selb = 1'b0, word_ready = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic [3:0] setup = 4'd1;
  logic cs_n, sclk, sdo_a, sdo_b, word_valid, frame_done;
  logic [23:0] word_data;
  logic [2:0]  word_chan;

  int n_checks = 0, n_err = 0;
  int cur_seed = 0;
  int idx = 0;
  bit wd_hit = 1'b0;

  always #10 clk = ~clk;

  adc_dual_readout dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dual_i(dual), .single_b_i(selb),
    .half_div_i(half_div), .setup_i(setup), .cs_n_o(cs_n), .sclk_o(sclk),
    .sdo_a_i(sdo_a), .sdo_b_i(sdo_b), .word_valid_o(word_valid),
    .word_ready_i(word_ready), .word_data_o(word_data), .word_chan_o(word_chan),
    .frame_done_o(frame_done)
  );

  function automatic logic [17:0] chval(input int seed, input int ch);
    if (seed == 0) return ch[0] ? 18'h1FFFF : 18'h20000;
    return 18'(seed * 131071 + ch * 40503 + ch * ch * 977);
  endfunction

  // converter model: MSB present at chip select fall, advances on rising edge
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) idx <= 0;
    else      idx <= idx + 1;
  end

  always_comb begin
    logic [17:0] va, vb;
    va = chval(cur_seed, (idx / 18) % 8);
    vb = chval(cur_seed, ((idx / 18) + 4) % 8);
    sdo_a = (!cs_n && idx < 144) ? va[17 - (idx % 18)] : 1'b0;
    sdo_b = (!cs_n && idx < 144) ? vb[17 - (idx % 18)] : 1'b0;
  end

  // monitor, sampled at the falling system clock edge
  int rises = 0, cs_falls = 0, done_cnt = 0, setup_seen = 0;
  int idle_bad = 0, done_bad = 0, early_bad = 0, stab_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, first_rise = 1'b0, done_frame = 1'b0;
  logic hold_v = 1'b0;
  logic [23:0] hold_d;
  logic [2:0]  hold_c;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        cs_falls++; setup_seen = 0; first_rise = 1'b0; done_frame = 1'b0;
      end
      if (!cs_n && !sclk && !first_rise) setup_seen++;
      if (!prev_sclk && sclk) begin rises++; first_rise = 1'b1; end
      if (cs_n && sclk) idle_bad++;
      if (frame_done) begin
        done_cnt++; done_frame = 1'b1;
        if (!cs_n) done_bad++;
      end
      if (word_valid && !done_frame) early_bad++;
      if (hold_v && !(word_valid && word_data == hold_d && word_chan == hold_c)) stab_bad++;
      hold_v = word_valid && !word_ready;
      hold_d = word_data;
      hold_c = word_chan;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic collect(input int seed, input logic [3:0] pat, input int hold, input bit poke,
                         input bit dual_mode);
    int k = 0;
    int c = 0;
    while (k < 8 && !wd_hit) begin
      @(posedge clk); #1;
      word_ready = (c < hold) ? 1'b0 : pat[c % 4];
      start = poke && (c == hold / 2 || c == hold - 10);
      c++;
      @(negedge clk);
      if (word_valid && word_ready) begin
        logic [17:0] v;
        v = chval(seed, k);
        chk(word_chan == 3'(k), "R7 channel order", word_chan, k);
        chk(word_data == {{6{v[17]}}, v},
            dual_mode ? "R5 R4 R7 data word" : "R6 R4 R7 data word",
            word_data, {{6{v[17]}}, v});
        k++;
      end
    end
    @(posedge clk); #1;
    word_ready = 1'b0;
    start = 1'b0;
  endtask

  task automatic run_frame(input vec_t v, input int hold, input bit poke);
    int r0, f0, d0, eb0, db0;
    dual = v.dual; selb = v.selb; half_div = v.half; setup = v.setup;
    cur_seed = int'(v.seed);
    r0 = rises; f0 = cs_falls; d0 = done_cnt; eb0 = early_bad; db0 = done_bad;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    collect(int'(v.seed), v.rdy, hold, poke, v.dual);
    repeat (20) @(negedge clk);
    chk(rises - r0 == (v.dual ? 72 : 144), "R1 rising edge count", rises - r0, v.dual ? 72 : 144);
    chk(cs_falls - f0 == 1, "R1 R10 single chip select low period", cs_falls - f0, 1);
    chk(setup_seen == ((v.setup == 0) ? 1 : int'(v.setup)), "R3 setup gap",
        setup_seen, (v.setup == 0) ? 1 : int'(v.setup));
    chk(done_cnt - d0 == 1, "R9 done pulse count", done_cnt - d0, 1);
    chk(done_bad == db0 && early_bad == eb0, "R9 done after chip select, before words",
        early_bad - eb0 + done_bad - db0, 0);
    chk(cs_n && !word_valid, "R10 idle after frame", {cs_n, word_valid}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_checks++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n at reset", cs_n, 1);
    chk(sclk == 1'b0, "R11 sclk at reset", sclk, 0);
    chk(word_valid == 1'b0 && frame_done == 1'b0, "R11 stream idle at reset",
        {word_valid, frame_done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      if (!wd_hit) run_frame(VECS[i], 0, 1'b0);
    end

    // R10: starts mid-frame and during a stalled drain are ignored
    if (!wd_hit) run_frame('{1'b1, 1'b0, 8'd1, 4'd1, 8'd33, 4'hF}, 200, 1'b1);
    // R2 R8: whole-run monitors
    chk(idle_bad == 0, "R2 sclk low while cs_n high", idle_bad, 0);
    chk(stab_bad == 0, "R8 stalled word held", stab_bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule